// File: doc/BRIEF.md
# Counter Enable Set Register

This block keeps the run/stop enable bits for a bank of performance counters: one cycle counter and up to 31 event counters. Software sees them as a 64-bit system register in which writing a 1 turns an enable on and writing a 0 leaves it alone. A companion clear register, decoded elsewhere, reaches the same storage through a separate clear port. The enable vector goes straight to the counters.

Only part of the event range is visible at any time. The visible count is the global implemented count. For guest accesses (privilege level 0 or 1 while the hypervisor level is enabled), it is the hypervisor's partition count instead. Bits at or above that limit read as zero, ignore writes and stay off at the counters. Their stored value is kept, so a later rise in the limit brings them back. The cycle-counter bit is always visible.

Top module: `cnt_enable_set_reg`

## Requirements
- R1: While reset is asserted, and after it is released, every stored enable is zero, so `cnt_en` and `reg_rdata` read zero.
- R2: `reg_rdata[63:32]` is always zero. `reg_wdata[63:32]` has no effect on any stored bit.
- R3: Bit 31 is the cycle-counter enable and is visible and writable whatever the limit. Bit n, for n from 0 to 30, is the enable of event counter n.
- R4: A write is a cycle with `reg_sel` and `reg_wr` both high. Each visible bit written as 1 is set at the next rising clock edge. Bits written as 0 are unchanged, and nothing changes when `reg_sel` is low.
- R5: The effective limit N is `hyp_count` when `hyp_en` is 1 and `priv_level` is 0 or 1. For any other combination it is `impl_count`. N ranges from 0 to 31, and 31 makes all event bits visible.
- R6: Event bits n with n >= N read as zero on `reg_rdata`, are zero on `cnt_en`, and are not set by writes.
- R7: A stored bit hidden by a lower N keeps its value. When N rises again, the bit reappears on `reg_rdata` and `cnt_en`.
- R8: A cycle with `clr_wr` high clears, at the next edge, each visible bit whose `clr_wdata` bit is 1. Hidden bits are not cleared.
- R9: When a write and a clear both target the same bit in one cycle, that bit ends up cleared.
- R10: `reg_rdata[31:0]` is the visible enable state whenever `reg_sel` is high. It is combinational, with no cycle of delay. It is all zero when `reg_sel` is low.
- R11: `cnt_en` always equals the visible enable state, independent of `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_wdata | input | 64 | Write data, a 1 sets the enable |
| reg_rdata | output | 64 | Read data |
| clr_wr | input | 1 | Clear strobe from the companion clear register |
| clr_wdata | input | 32 | Clear data, a 1 clears the enable |
| impl_count | input | 5 | Implemented event-counter count |
| hyp_count | input | 5 | Hypervisor partition count for guest accesses |
| priv_level | input | 2 | Current privilege level, 0 to 3 |
| hyp_en | input | 1 | Hypervisor level implemented and enabled |
| cnt_en | output | 32 | Enable vector to the counters |

## Verification
The bench aims at the edges of the visible window. It sets N to 0, where only the cycle bit may change, and to 31. It lowers and raises N around stored ones: a design that cleared hidden bits would lose them when N rose again, and one that did not mask them would leak enables to counters that software cannot see. It hits the same bit with a set and a clear in one cycle, which catches a design that lets the set win. It walks the privilege levels with the hypervisor flag on and off, which catches a limit chosen at the wrong level. A write of zeros, a write with the select low and ones in the upper word all expose a design that stores plainly instead of setting only.

// File: rtl/cen_pkg.sv
package cen_pkg;
  typedef enum logic [1:0] {
    PRIV_USER   = 2'd0,
    PRIV_KERNEL = 2'd1,
    PRIV_HYP    = 2'd2,
    PRIV_MON    = 2'd3
  } priv_e;

  localparam int unsigned DEF_NUM_EVT = 31;
  localparam int unsigned DEF_REG_W   = 64;
endpackage

// File: rtl/cen_limit_sel.sv
module cen_limit_sel #(
  parameter int NUM_EVT = cen_pkg::DEF_NUM_EVT,
  localparam int EN_W   = NUM_EVT + 1,
  localparam int LIM_W  = $clog2(NUM_EVT + 1)
) (
  input  logic [LIM_W-1:0] impl_count,
  input  logic [LIM_W-1:0] hyp_count,
  input  logic [1:0]       priv_level,
  input  logic             hyp_en,
  output logic [EN_W-1:0]  vis_mask
);
  import cen_pkg::*;

  logic             guest_acc;
  logic [LIM_W-1:0] eff_lim;

  always_comb begin
    guest_acc = hyp_en && ((priv_e'(priv_level) == PRIV_USER) ||
                           (priv_e'(priv_level) == PRIV_KERNEL));
    eff_lim   = guest_acc ? hyp_count : impl_count;
  end

  // event bits are visible below the limit; the cycle bit always is
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign vis_mask[i] = (32'(eff_lim) > i);
  end
  assign vis_mask[EN_W-1] = 1'b1;
endmodule

// File: rtl/cen_bit_store.sv
module cen_bit_store #(
  parameter int W = cen_pkg::DEF_NUM_EVT + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] state_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic upd;
    logic nxt;

    always_comb begin
      upd = set_vec[i] | clr_vec[i];
      nxt = clr_vec[i] ? 1'b0 : 1'b1;   // clear has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q[i] <= 1'b0;
      else if (upd) state_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/cnt_enable_set_reg.sv
module cnt_enable_set_reg #(
  parameter int NUM_EVT = cen_pkg::DEF_NUM_EVT,
  parameter int REG_W   = cen_pkg::DEF_REG_W,
  localparam int EN_W   = NUM_EVT + 1,
  localparam int LIM_W  = $clog2(NUM_EVT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             clr_wr,
  input  logic [EN_W-1:0]  clr_wdata,
  input  logic [LIM_W-1:0] impl_count,
  input  logic [LIM_W-1:0] hyp_count,
  input  logic [1:0]       priv_level,
  input  logic             hyp_en,
  output logic [EN_W-1:0]  cnt_en
);
  logic [EN_W-1:0] vis_mask;
  logic [EN_W-1:0] set_vec;
  logic [EN_W-1:0] clr_vec;
  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] vis_en;
  logic            wr_fire;
  logic            unused_wr_hi;

  cen_limit_sel #(.NUM_EVT(NUM_EVT)) lim_i (
    .impl_count (impl_count),
    .hyp_count  (hyp_count),
    .priv_level (priv_level),
    .hyp_en     (hyp_en),
    .vis_mask   (vis_mask)
  );

  always_comb begin
    wr_fire      = reg_sel & reg_wr;
    set_vec      = wr_fire ? (reg_wdata[EN_W-1:0] & vis_mask) : '0;
    clr_vec      = clr_wr  ? (clr_wdata & vis_mask)           : '0;
    unused_wr_hi = ^reg_wdata[REG_W-1:EN_W];
  end

  cen_bit_store #(.W(EN_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .state_q (en_q)
  );

  always_comb begin
    vis_en    = en_q & vis_mask;
    cnt_en    = vis_en;
    reg_rdata = reg_sel ? {{(REG_W-EN_W){1'b0}}, vis_en} : '0;
  end
endmodule

// File: rtl/cen_set_reg_chk.sv
module cen_set_reg_chk #(
  parameter int NUM_EVT = cen_pkg::DEF_NUM_EVT,
  parameter int REG_W   = cen_pkg::DEF_REG_W,
  localparam int EN_W   = NUM_EVT + 1,
  localparam int LIM_W  = $clog2(NUM_EVT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             clr_wr,
  input logic [EN_W-1:0]  clr_wdata,
  input logic [LIM_W-1:0] impl_count,
  input logic [LIM_W-1:0] hyp_count,
  input logic [1:0]       priv_level,
  input logic             hyp_en,
  input logic [EN_W-1:0]  cnt_en,
  input logic [EN_W-1:0]  en_q
);
  logic [EN_W-1:0] msk;
  logic [LIM_W-1:0] lim;
  logic wr_now;

  always_comb begin
    lim = (hyp_en && priv_level < 2'd2) ? hyp_count : impl_count;
    for (int i = 0; i < EN_W; i++)
      msk[i] = (i == EN_W-1) || (32'(lim) > i);
    wr_now = reg_sel && reg_wr;
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:EN_W] == '0);

  assert_hidden_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en & ~msk) == '0);

  assert_write_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && !clr_wr) |=>
      ((en_q & $past(reg_wdata[EN_W-1:0] & msk)) == $past(reg_wdata[EN_W-1:0] & msk)));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((en_q & $past(clr_wdata & msk)) == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_now && !clr_wr) |=> $stable(en_q));

  assert_read_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[EN_W-1:0] == cnt_en));

  assert_read_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata == '0));
endmodule

bind cnt_enable_set_reg cen_set_reg_chk #(.NUM_EVT(NUM_EVT), .REG_W(REG_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .clr_wr     (clr_wr),
  .clr_wdata  (clr_wdata),
  .impl_count (impl_count),
  .hyp_count  (hyp_count),
  .priv_level (priv_level),
  .hyp_en     (hyp_en),
  .cnt_en     (cnt_en),
  .en_q       (en_q)
);

// File: tb/cnt_enable_set_reg_tb.sv
module cnt_enable_set_reg_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_sel;
  logic        reg_wr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        clr_wr;
  logic [31:0] clr_wdata;
  logic [4:0]  impl_count;
  logic [4:0]  hyp_count;
  logic [1:0]  priv_level;
  logic        hyp_en;
  logic [31:0] cnt_en;

  int n_run;
  int n_fail;
  bit done;
  logic [31:0] m_store;

  cnt_enable_set_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_wr(clr_wr),
    .clr_wdata(clr_wdata), .impl_count(impl_count), .hyp_count(hyp_count),
    .priv_level(priv_level), .hyp_en(hyp_en), .cnt_en(cnt_en)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic logic [31:0] f_mask(logic [4:0] ic, logic [4:0] hc,
                                         logic [1:0] pl, logic he);
    logic [4:0] n;
    logic [31:0] m;
    n = (he && (pl == 2'd0 || pl == 2'd1)) ? hc : ic;
    for (int i = 0; i < 31; i++) m[i] = (i < int'(n));
    m[31] = 1'b1;
    return m;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive, check combinational outputs, clock, update model
  task automatic step(logic s, logic w, logic [63:0] wd, logic c, logic [31:0] cd);
    logic [31:0] m;
    reg_sel = s; reg_wr = w; reg_wdata = wd; clr_wr = c; clr_wdata = cd;
    #1;
    m = f_mask(impl_count, hyp_count, priv_level, hyp_en);
    chk("R11 cnt_en", {32'd0, cnt_en}, {32'd0, m_store & m});
    chk("R10 rdata", reg_rdata, s ? {32'd0, m_store & m} : 64'd0);
    @(posedge clk);
    m_store = (m_store | ((s && w) ? (wd[31:0] & m) : 32'd0)) & ~(c ? (cd & m) : 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_vis(string tag, logic [31:0] exp);
    reg_sel = 1'b1; reg_wr = 1'b0; clr_wr = 1'b0;
    #1;
    chk(tag, reg_rdata, {32'd0, exp});
  endtask

  task automatic set_lim(logic [4:0] ic, logic [4:0] hc, logic [1:0] pl, logic he);
    impl_count = ic; hyp_count = hc; priv_level = pl; hyp_en = he;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0; m_store = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_sel = 0; reg_wr = 0; reg_wdata = '0; clr_wr = 0; clr_wdata = '0;
    set_lim(5'd31, 5'd31, 2'd3, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset cnt_en", {32'd0, cnt_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_vis("R1 after reset", 32'h0);

    // N = 0: only the cycle bit can be set; upper word ignored
    set_lim(5'd0, 5'd0, 2'd3, 1'b0);
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    expect_vis("R3 R6 N0 only cycle bit", 32'h8000_0000);
    chk("R2 upper zero", {32'd0, reg_rdata[63:32]}, 64'd0);

    // writing zero has no effect; deselected write ignored
    set_lim(5'd31, 5'd0, 2'd3, 1'b0);
    step(1, 1, 64'h0, 0, 0);
    expect_vis("R4 zero write", 32'h8000_0000);
    step(0, 1, 64'h0000_0000_0000_00F0, 0, 0);
    expect_vis("R4 unselected write", 32'h8000_0000);
    step(1, 1, 64'hABCD_0000_0000_0005, 0, 0);
    expect_vis("R3 event bits", 32'h8000_0005);

    // set and clear same bits same cycle
    step(1, 1, 64'h8000_0004, 1, 32'h8000_0004);
    expect_vis("R9 clear wins", 32'h0000_0001);

    // hidden bits retained across limit change
    step(1, 1, 64'h7FFF_FFFF, 0, 0);
    expect_vis("R4 all set", 32'h7FFF_FFFF);
    step(1, 1, 64'h8000_0000, 0, 0);
    set_lim(5'd4, 5'd0, 2'd3, 1'b0);
    expect_vis("R6 limit 4", 32'h8000_000F);
    step(1, 0, 64'h0, 1, 32'hFFFF_FFF0);
    expect_vis("R8 masked clear", 32'h0000_000F);
    set_lim(5'd31, 5'd0, 2'd3, 1'b0);
    expect_vis("R7 reappear", 32'h7FFF_FFFF);

    // limit source selection
    set_lim(5'd31, 5'd2, 2'd0, 1'b1);
    expect_vis("R5 guest level0", 32'h0000_0003);
    set_lim(5'd31, 5'd2, 2'd1, 1'b1);
    expect_vis("R5 guest level1", 32'h0000_0003);
    set_lim(5'd31, 5'd2, 2'd2, 1'b1);
    expect_vis("R5 hyp level", 32'h7FFF_FFFF);
    set_lim(5'd31, 5'd2, 2'd1, 1'b0);
    expect_vis("R5 hyp disabled", 32'h7FFF_FFFF);

    // select low: read data zero, enables still driven
    reg_sel = 1'b0; #1;
    chk("R10 deselected read", reg_rdata, 64'd0);
    chk("R11 cnt_en deselected", {32'd0, cnt_en}, 64'h7FFF_FFFF);
    @(negedge clk);

    // constrained random
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)
        set_lim(5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
                2'($urandom_range(0, 3)), r[4]);
      step(r[5] | r[6], r[7] | r[8], {$urandom, $urandom & $urandom},
           r[9] & r[10], $urandom & $urandom);
    end

    finish_run();
  end
endmodule